// File: doc/BRIEF.md
# Calendar Clock Counter with Deferred Register Commit

This block is a real-time calendar core. It counts seconds, minutes, hours, day of month, month and year, and advances them once for each rising edge of an asynchronous one-hertz tick input. A two-flop synchronizer and an edge detector turn that input into a single-cycle pulse in the system clock domain. Software sees three word registers through a plain write strobe with a combinational read mux. The control word carries two busy flags. One word packs the clock time and one packs the calendar date.

A software write to the time or date word is not applied immediately. Each word has a commit slot, a two-state machine. In SLOT_IDLE it holds nothing. A write moves it to SLOT_PEND, captures the value and raises the word's busy flag. On the next tick pulse with no write in the same cycle, the slot loads its value into the counter and returns to SLOT_IDLE (transition PEND→IDLE), and the busy flag drops in that same cycle. A write while the slot is in SLOT_PEND keeps it in SLOT_PEND (PEND→PEND) and replaces the captured value. Software polls a busy flag before it writes the other word.

Leap years are not computed. Software sets a leap flag in the date word, and February has 29 days while that flag is set. The year field width is a parameter. The default is 8 bits with the leap flag at bit 24. A 6-bit setting places the leap flag at bit 22.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads day 1, month 1, year 0, leap 0 (0x00000101), and the control word reads 0.
- R2: Register map (byte offsets): control at 0x00, with the time busy flag at bit 8 and the date busy flag at bit 7. Date at 0x04, with day in bits 4:0, month in bits 11:8, year in bits 23:16 and the leap flag at bit 24. Time at 0x08, with seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Every other bit reads 0.
- R3: A write to the time word (or the date word) sets its busy flag from the next cycle. Until the commit, the word still reads its previous counter value.
- R4: A pending value is loaded at the first tick pulse. The tick takes effect on the third rising clock edge after tick_in rises. The busy flag clears on that same edge.
- R5: On each tick with no time commit, seconds increment. At 59 (or above), seconds wrap to 0 and carry into minutes. Minutes behave the same way and carry into hours. Hours wrap from 23 (or above) to 0 and carry into the day.
- R6: Months 4, 6, 9 and 11 have 30 days. February has 28 days, or 29 when the leap flag is 1. All other months have 31 days. A day carry on the last day sets the day to 1 and advances the month.
- R7: Month 12 wraps to 1 and increments the year. The year wraps from all ones to 0. The leap flag is never changed by counting.
- R8: On a tick that commits the time word, no carry reaches the date. On a tick that commits the date word, the date takes the committed value instead of counting. When several writes arrive while a word is busy, the last one is committed.
- R9: Writes to the control word or to an unmapped offset change nothing. Reads from an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Asynchronous one-hertz tick; its rising edge advances the calendar |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
A commit slot stuck in the wrong state shows at the control word on the very next read. A busy flag that never clears is visible one tick later, and the new time or date never appears. A wrong carry or month-length decision in the counter surfaces only at the tick that crosses that boundary, so the directed cases place the counter one second before each boundary. Those cases cover minute, hour, day, month-length, leap-February and year wrap. Randomized dates and times, biased toward field maxima, are compared after every tick against a bench calendar model, so a corrupted field is seen within one tick of the error.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 32;
    localparam int CTRL_OFS    = 0;
    localparam int DATE_OFS    = 4;
    localparam int TIME_OFS    = 8;
    localparam int BUSY_T_BIT  = 8;
    localparam int BUSY_D_BIT  = 7;
    localparam int SEC_W       = 6;
    localparam int MIN_W       = 6;
    localparam int HR_W        = 5;
    localparam int DAY_W       = 5;
    localparam int MON_W       = 4;
    localparam int TIME_W      = HR_W + MIN_W + SEC_W;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_PEND = 1'b1
    } slot_state_e;

    function automatic logic [DAY_W-1:0] days_in_month(input logic [MON_W-1:0] mon,
                                                       input logic leap);
        logic [DAY_W-1:0] len;
        case (mon)
            4'd2:                      len = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   len = 5'd30;
            default:                   len = 5'd31;
        endcase
        return len;
    endfunction
endpackage

// File: rtl/cal_tick_sync.sv
module cal_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tick_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign tick_pulse = sync_q[STAGES-1] & ~last_q;

    // R4: one input edge gives a single-cycle pulse
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);
endmodule

// File: rtl/cal_commit_slot.sv
module cal_commit_slot
    import cal_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             tick,
    output logic             busy,
    output logic             load,
    output logic [WIDTH-1:0] load_data
);
    slot_state_e      state_q, state_d;
    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold_q <= '0;
        else if (wr_en) hold_q <= wr_data;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (wr_en)          state_d = SLOT_PEND;
            SLOT_PEND: if (tick && !wr_en) state_d = SLOT_IDLE;
            default:                       state_d = SLOT_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q == SLOT_PEND);
        load      = (state_q == SLOT_PEND) && tick && !wr_en;
        load_data = hold_q;
    end

    // R3: a write leaves the slot busy in the next cycle
    p_busy_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy);
    // R4: a commit releases the busy flag
    p_busy_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !busy);
    // R3: with no tick the flag is held
    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy);
endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
#(
    parameter int YEAR_W = 8,
    localparam int DATE_W = 1 + YEAR_W + MON_W + DAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_time,
    input  logic [TIME_W-1:0] time_in,
    input  logic              ld_date,
    input  logic [DATE_W-1:0] date_in,
    output logic [TIME_W-1:0] time_o,
    output logic [DATE_W-1:0] date_o
);
    logic [SEC_W-1:0]  sec_q;
    logic [MIN_W-1:0]  min_q;
    logic [HR_W-1:0]   hr_q;
    logic [DAY_W-1:0]  day_q;
    logic [MON_W-1:0]  mon_q;
    logic [YEAR_W-1:0] yr_q;
    logic              leap_q;

    logic sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap, time_carry;

    always_comb begin
        sec_wrap   = (sec_q >= 6'd59);
        min_wrap   = (min_q >= 6'd59);
        hr_wrap    = (hr_q  >= 5'd23);
        day_wrap   = (day_q >= days_in_month(mon_q, leap_q));
        mon_wrap   = (mon_q >= 4'd12);
        time_carry = sec_wrap && min_wrap && hr_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
            hr_q  <= '0;
        end else if (ld_time) begin
            {hr_q, min_q, sec_q} <= time_in;
        end else if (tick) begin
            sec_q <= sec_wrap ? '0 : sec_q + 6'd1;
            if (sec_wrap)
                min_q <= min_wrap ? '0 : min_q + 6'd1;
            if (sec_wrap && min_wrap)
                hr_q <= hr_wrap ? '0 : hr_q + 5'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            day_q  <= 5'd1;
            mon_q  <= 4'd1;
            yr_q   <= '0;
            leap_q <= 1'b0;
        end else if (ld_date) begin
            {leap_q, yr_q, mon_q, day_q} <= date_in;
        end else if (tick && time_carry && !ld_time) begin
            if (day_wrap) begin
                day_q <= 5'd1;
                mon_q <= mon_wrap ? 4'd1 : mon_q + 4'd1;
                if (mon_wrap)
                    yr_q <= yr_q + 1'b1;
            end else begin
                day_q <= day_q + 5'd1;
            end
        end
    end

    assign time_o = {hr_q, min_q, sec_q};
    assign date_o = {leap_q, yr_q, mon_q, day_q};

    // R5: counting keeps seconds within range
    p_sec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_time) |=> (sec_q <= 6'd59));
    // R4: a commit places the slot value into the counter
    p_load_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_time |=> (time_o == $past(time_in)));
    // R5: nothing moves without a tick
    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable({time_o, date_o}));
    // R7: counting never alters the leap flag
    p_leap_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_date |=> $stable(leap_q));
    // R6: a counted day is never zero
    p_day_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && time_carry && !ld_date && !ld_time) |=> (day_q != 5'd0));
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
    import cal_pkg::*;
#(
    parameter int YEAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int YEAR_LSB = 16;
    localparam int LEAP_BIT = YEAR_LSB + YEAR_W;
    localparam int DATE_W   = 1 + YEAR_W + MON_W + DAY_W;

    logic              tick_pulse;
    logic              wr_time, wr_date;
    logic              busy_t, busy_d, ld_t, ld_d;
    logic [TIME_W-1:0] wtime, ltime, cur_time;
    logic [DATE_W-1:0] wdate, ldate, cur_date;
    logic              wdata_unused;

    assign wr_time = bus_wr && (bus_addr == ADDR_W'(TIME_OFS));
    assign wr_date = bus_wr && (bus_addr == ADDR_W'(DATE_OFS));

    assign wtime = {bus_wdata[20:16], bus_wdata[13:8], bus_wdata[5:0]};
    assign wdate = {bus_wdata[LEAP_BIT], bus_wdata[YEAR_LSB +: YEAR_W],
                    bus_wdata[11:8], bus_wdata[4:0]};
    assign wdata_unused = ^{bus_wdata[DATA_W-1:LEAP_BIT+1], bus_wdata[15:14], bus_wdata[7:6]};

    cal_tick_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .tick_pulse (tick_pulse)
    );

    cal_commit_slot #(.WIDTH(TIME_W)) u_slot_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_time),
        .wr_data   (wtime),
        .tick      (tick_pulse),
        .busy      (busy_t),
        .load      (ld_t),
        .load_data (ltime)
    );

    cal_commit_slot #(.WIDTH(DATE_W)) u_slot_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_date),
        .wr_data   (wdate),
        .tick      (tick_pulse),
        .busy      (busy_d),
        .load      (ld_d),
        .load_data (ldate)
    );

    cal_counter #(.YEAR_W(YEAR_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_pulse),
        .ld_time (ld_t),
        .time_in (ltime),
        .ld_date (ld_d),
        .date_in (ldate),
        .time_o  (cur_time),
        .date_o  (cur_date)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFS)) begin
            bus_rdata[BUSY_T_BIT] = busy_t;
            bus_rdata[BUSY_D_BIT] = busy_d;
        end else if (bus_addr == ADDR_W'(TIME_OFS)) begin
            bus_rdata[20:16] = cur_time[TIME_W-1 -: HR_W];
            bus_rdata[13:8]  = cur_time[SEC_W +: MIN_W];
            bus_rdata[5:0]   = cur_time[SEC_W-1:0];
        end else if (bus_addr == ADDR_W'(DATE_OFS)) begin
            bus_rdata[LEAP_BIT]              = cur_date[DATE_W-1];
            bus_rdata[YEAR_LSB +: YEAR_W]    = cur_date[DAY_W+MON_W +: YEAR_W];
            bus_rdata[11:8]                  = cur_date[DAY_W +: MON_W];
            bus_rdata[4:0]                   = cur_date[DAY_W-1:0];
        end
    end

    // R8: a time commit never coincides with a date count step
    p_commit_no_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_t && !ld_d) |=> $stable(cur_date));
    // R9: control and unmapped writes leave the counters alone without a tick
    p_ignored_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_time && !wr_date && !tick_pulse) |=> $stable({cur_time, cur_date}));
endmodule

// File: tb/sim_cal_clock_core.sv
`timescale 1ns/1ps
module sim_cal_clock_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cal_clock_core u0 (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // bench calendar model
    logic [5:0] m_sec, m_min;
    logic [4:0] m_hr, m_day;
    logic [3:0] m_mon;
    logic [7:0] m_yr;
    logic       m_leap;
    logic       pend_t, pend_d;
    logic [31:0] pv_t, pv_d;

    function automatic logic [4:0] bm_len(input logic [3:0] mon, input logic leap);
        if (mon == 4'd2) return leap ? 5'd29 : 5'd28;
        if (mon == 4'd4 || mon == 4'd6 || mon == 4'd9 || mon == 4'd11) return 5'd30;
        return 5'd31;
    endfunction

    function automatic logic [31:0] pk_time(input logic [4:0] h, input logic [5:0] mi, input logic [5:0] s);
        return {11'd0, h, 2'd0, mi, 2'd0, s};
    endfunction

    function automatic logic [31:0] pk_date(input logic lp, input logic [7:0] y, input logic [3:0] mo, input logic [4:0] d);
        return {7'd0, lp, y, 4'd0, mo, 3'd0, d};
    endfunction

    function automatic logic [31:0] exp_time();
        return pk_time(m_hr, m_min, m_sec);
    endfunction

    function automatic logic [31:0] exp_date();
        return pk_date(m_leap, m_yr, m_mon, m_day);
    endfunction

    task automatic model_tick();
        logic carry;
        carry = 1'b0;
        if (pend_t) begin
            m_sec = pv_t[5:0]; m_min = pv_t[13:8]; m_hr = pv_t[20:16];
            pend_t = 1'b0;
        end else begin
            carry = (m_sec == 59) && (m_min == 59) && (m_hr == 23);
            if (m_sec == 59) begin
                m_sec = 0;
                if (m_min == 59) begin
                    m_min = 0;
                    m_hr = (m_hr == 23) ? 5'd0 : m_hr + 5'd1;
                end else m_min = m_min + 6'd1;
            end else m_sec = m_sec + 6'd1;
        end
        if (pend_d) begin
            m_day = pv_d[4:0]; m_mon = pv_d[11:8]; m_yr = pv_d[23:16]; m_leap = pv_d[24];
            pend_d = 1'b0;
        end else if (carry) begin
            if (m_day == bm_len(m_mon, m_leap)) begin
                m_day = 1;
                if (m_mon == 12) begin m_mon = 1; m_yr = m_yr + 8'd1; end
                else m_mon = m_mon + 4'd1;
            end else m_day = m_day + 5'd1;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 5'd8) begin pend_t = 1'b1; pv_t = d; end
        if (a == 5'd4) begin pend_d = 1'b1; pv_d = d; end
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_tick();
        @(negedge clk); tick_in = 1'b1;
        repeat (4) @(negedge clk);
        tick_in = 1'b0;
        repeat (3) @(negedge clk);
        model_tick();
    endtask

    task automatic check_model(input string req);
        logic [31:0] r;
        bus_read(5'd8, r); chk(req, r, exp_time());
        bus_read(5'd4, r); chk(req, r, exp_date());
    endtask

    task automatic set_both(input logic [31:0] t, input logic [31:0] d);
        bus_write(5'd8, t);
        bus_write(5'd4, d);
        do_tick();
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_leap = 0;
        pend_t = 0; pend_d = 0; pv_t = 0; pv_d = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        bus_read(5'd8, r); chk("R1 time", r, 32'h0000_0000);
        bus_read(5'd4, r); chk("R1 date", r, 32'h0000_0101);
        bus_read(5'd0, r); chk("R1 ctrl", r, 32'h0000_0000);

        // R3 busy flags and old readback
        bus_write(5'd8, pk_time(5'd12, 6'd34, 6'd56));
        bus_read(5'd0, r); chk("R3 time busy bit8", r, 32'h0000_0100);
        bus_read(5'd8, r); chk("R3 old time", r, 32'h0000_0000);
        bus_write(5'd4, pk_date(1'b0, 8'd3, 4'd7, 5'd9));
        bus_read(5'd0, r); chk("R3 both busy", r, 32'h0000_0180);

        // R4 tick latency: third edge after tick_in rises
        @(negedge clk); tick_in = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(5'd8, r); chk("R4 not yet", r, 32'h0000_0000);
        bus_read(5'd0, r); chk("R4 still busy", r, 32'h0000_0180);
        @(negedge clk);
        bus_read(5'd8, r); chk("R4 loaded time", r, pk_time(5'd12, 6'd34, 6'd56));
        bus_read(5'd0, r); chk("R4 busy cleared", r, 32'h0000_0000);
        @(negedge clk); tick_in = 1'b0;
        repeat (3) @(negedge clk);
        model_tick();
        check_model("R4 commit");

        // R2 fields and unused bits: write all ones
        set_both(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        bus_read(5'd8, r); chk("R2 time mask", r, 32'h001F_3F3F);
        bus_read(5'd4, r); chk("R2 date mask", r, 32'h01FF_0F1F);

        // R5 time carries
        set_both(pk_time(5'd10, 6'd59, 6'd59), pk_date(1'b0, 8'd5, 4'd5, 5'd10));
        do_tick();
        bus_read(5'd8, r); chk("R5 min/hour carry", r, pk_time(5'd11, 6'd0, 6'd0));
        do_tick();
        bus_read(5'd8, r); chk("R5 second step", r, pk_time(5'd11, 6'd0, 6'd1));

        // R6 month lengths
        set_both(pk_time(5'd23, 6'd59, 6'd59), pk_date(1'b0, 8'd5, 4'd2, 5'd28));
        do_tick();
        bus_read(5'd4, r); chk("R6 feb28 no leap", r, pk_date(1'b0, 8'd5, 4'd3, 5'd1));
        bus_read(5'd8, r); chk("R5 day carry time", r, 32'h0);
        set_both(pk_time(5'd23, 6'd59, 6'd59), pk_date(1'b1, 8'd6, 4'd2, 5'd28));
        do_tick();
        bus_read(5'd4, r); chk("R6 feb28 leap", r, pk_date(1'b1, 8'd6, 4'd2, 5'd29));
        set_both(pk_time(5'd23, 6'd59, 6'd59), pk_date(1'b0, 8'd6, 4'd4, 5'd30));
        do_tick();
        bus_read(5'd4, r); chk("R6 apr30", r, pk_date(1'b0, 8'd6, 4'd5, 5'd1));
        set_both(pk_time(5'd23, 6'd59, 6'd59), pk_date(1'b0, 8'd6, 4'd5, 5'd30));
        do_tick();
        bus_read(5'd4, r); chk("R6 may30", r, pk_date(1'b0, 8'd6, 4'd5, 5'd31));

        // R7 year step and wrap, leap kept
        set_both(pk_time(5'd23, 6'd59, 6'd59), pk_date(1'b1, 8'd255, 4'd12, 5'd31));
        do_tick();
        bus_read(5'd4, r); chk("R7 year wrap", r, pk_date(1'b1, 8'd0, 4'd1, 5'd1));
        set_both(pk_time(5'd23, 6'd59, 6'd59), pk_date(1'b0, 8'd9, 4'd12, 5'd31));
        do_tick();
        bus_read(5'd4, r); chk("R7 year step", r, pk_date(1'b0, 8'd10, 4'd1, 5'd1));

        // R8 time commit blocks the carry
        set_both(pk_time(5'd23, 6'd59, 6'd59), pk_date(1'b0, 8'd9, 4'd3, 5'd31));
        bus_write(5'd8, pk_time(5'd10, 6'd0, 6'd0));
        do_tick();
        bus_read(5'd4, r); chk("R8 no carry on commit", r, pk_date(1'b0, 8'd9, 4'd3, 5'd31));
        bus_read(5'd8, r); chk("R8 committed time", r, pk_time(5'd10, 6'd0, 6'd0));
        // R8 last write wins
        bus_write(5'd8, pk_time(5'd1, 6'd2, 6'd3));
        bus_write(5'd8, pk_time(5'd4, 6'd5, 6'd6));
        do_tick();
        bus_read(5'd8, r); chk("R8 last write wins", r, pk_time(5'd4, 6'd5, 6'd6));

        // R9 ignored writes
        bus_write(5'd0, 32'hFFFF_FFFF);
        bus_read(5'd0, r); chk("R9 ctrl write ignored", r, 32'h0);
        bus_write(5'd12, 32'h1234_5678);
        bus_read(5'd12, r); chk("R9 unmapped read", r, 32'h0);
        check_model("R9 state untouched");

        // random stimulus, model compared every tick
        for (int i = 0; i < 24; i++) begin
            logic [5:0] s, mi;
            logic [4:0] h, d;
            logic [3:0] mo;
            logic [7:0] y;
            logic lp;
            s  = ($urandom % 3 == 0) ? 6'd59 : 6'(58 + $urandom % 2 - ($urandom % 2) * 50);
            mi = ($urandom % 2 == 0) ? 6'd59 : 6'($urandom % 60);
            h  = ($urandom % 2 == 0) ? 5'd23 : 5'($urandom % 24);
            mo = 4'(1 + $urandom % 12);
            y  = ($urandom % 4 == 0) ? 8'd255 : 8'($urandom % 256);
            lp = 1'($urandom % 2);
            d  = ($urandom % 2 == 0) ? bm_len(mo, lp) : 5'(1 + $urandom % 28);
            set_both(pk_time(h, mi, s), pk_date(lp, y, mo, d));
            check_model("R5 random commit");
            for (int k = 0; k < 2; k++) begin
                do_tick();
                check_model("R6 random count");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule